// File: doc/BRIEF.md
# System Interrupt Level Router

This block collects 32 level-sensitive device interrupt lines and a set of per-processor timer lines into one pending register. A disable register holds one bit per source. Software sets it and clears it through separate write ports. The disable register gates the pending bits. Each surviving source is translated through a fixed, irregular table into a processor interrupt level. The resulting 16-bit level vector is steered to exactly one processor, chosen by a programmable target register. Every other processor sees an all-zero vector.

Software reaches the block through a word-indexed register port. Reads are combinational and writes commit on the clock edge. The top bit of the disable register acts as a master switch: while it is set, no processor receives any level. Setting a disable bit also drops that source's pending bit. The pending bit stays clear until the source line falls and rises again. One source bit position, chosen by a parameter, is shared with the timer lines. Any asserted timer line holds that pending bit set.

Top module: `irq_level_router_top`

## Requirements
- R1: Each source bit b maps to a level; for b = 0..31 the levels are 2,3,5,7,9,11,0,14,3,5,7,9,11,13,12,12,6,0,4,10,8,0,11,0,0,0,0,0,15,0,15,0. An enabled, pending source sets bit (level) of the target processor's 16-bit vector, and sources that share a level merge into one bit.
- R2: A source whose level is 0 (bits 6,17,21,23..27,29,31) is ignored. It never sets a pending bit and never changes any output.
- R3: A rising source line sets its pending bit. A falling source line clears it.
- R4: Read index 0 returns the pending register with bit 31 forced to 0. Index 1 returns the disable register ANDed with 0xF05DFF80. Index 4 returns the target processor number, zero-extended. All other indices read 0.
- R5: A write to index 2 clears the disable bits selected by (data AND 0xF05DFF80).
- R6: A write to index 3 sets the disable bits selected by (data AND 0xF05DFF80) and clears the same pending bits. This has priority over a source edge in the same cycle.
- R7: A write to index 4 loads the target processor from the low log2(NUM_CPU) data bits.
- R8: While disable bit 31 is set, every processor's level vector is zero.
- R9: Only the target processor, at bits [16*t+15:16*t] of the output, receives a nonzero vector. All others are zero.
- R10: After reset the disable register is 0xF05DFF80, pending is 0, the target is 0, and all outputs are 0.
- R11: While any timer line is high, pending bit TIMER_BIT is set. When all timer lines are low and the source line at that bit is low, the bit clears.
- R12: A register write or a source change is visible on the level outputs right after the clock edge that samples it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_in | input | 32 | Level-sensitive device interrupt lines |
| timer_in | input | NUM_CPU | Per-processor timer lines, merged onto pending bit TIMER_BIT |
| reg_idx | input | 3 | Word index of the register access |
| reg_wr | input | 1 | Write strobe, committed on the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_idx |
| cpu_lvl | output | 16*NUM_CPU | Level vectors, 16 bits per processor, processor 0 in the low bits |

## Verification
The bench builds the block with NUM_CPU = 16 and TIMER_BIT = 19. TIMER_BIT = 19 moves the timer away from the default position, so a timer pulse shows up as level 10 and as pending bit 19. Sixteen processors put the full 4-bit target field in use. Steering to processor 5 then exercises the upper slices of the 256-bit output while all other slices stay at zero. Table vectors cover merged shared levels, the all-ones pattern and ignored level-0 sources. Directed steps cover the disable-versus-edge race, the master switch and the latency edge.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int SRC_N = 32;
  localparam int LVL_N = 16;
  localparam int LVL_W = 4;
  localparam int GLOBAL_OFF_BIT = 31;
  localparam logic [SRC_N-1:0] DIS_VALID = 32'hF05DFF80;

  localparam logic [2:0] IDX_PEND   = 3'd0;
  localparam logic [2:0] IDX_DIS    = 3'd1;
  localparam logic [2:0] IDX_ENABLE = 3'd2;
  localparam logic [2:0] IDX_MASK   = 3'd3;
  localparam logic [2:0] IDX_TGT    = 3'd4;

  // fixed source-bit to processor-level translation
  function automatic logic [LVL_W-1:0] src_level(input int unsigned b);
    logic [LVL_W-1:0] l;
    case (b)
      0: l = 4'd2;   1: l = 4'd3;   2: l = 4'd5;   3: l = 4'd7;
      4: l = 4'd9;   5: l = 4'd11;  7: l = 4'd14;  8: l = 4'd3;
      9: l = 4'd5;   10: l = 4'd7;  11: l = 4'd9;  12: l = 4'd11;
      13: l = 4'd13; 14: l = 4'd12; 15: l = 4'd12; 16: l = 4'd6;
      18: l = 4'd4;  19: l = 4'd10; 20: l = 4'd8;  22: l = 4'd11;
      28: l = 4'd15; 30: l = 4'd15;
      default: l = 4'd0;
    endcase
    return l;
  endfunction

  // sources that own a nonzero level
  function automatic logic [SRC_N-1:0] live_mask();
    logic [SRC_N-1:0] m;
    for (int b = 0; b < SRC_N; b++) m[b] = (src_level(b) != '0);
    return m;
  endfunction

endpackage

// File: rtl/irq_pending_capture.sv
module irq_pending_capture
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU   = 16,
  parameter int TIMER_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_in,
  input  logic [NUM_CPU-1:0] timer_in,
  input  logic [SRC_N-1:0] clr_mask,
  output logic [SRC_N-1:0] pending
);

  localparam logic [SRC_N-1:0] LIVE = live_mask();

  logic [SRC_N-1:0] line_eff;
  logic [SRC_N-1:0] line_q;
  logic [SRC_N-1:0] pend_q, pend_nxt;
  logic [SRC_N-1:0] rise, fall;

  always_comb begin
    line_eff = src_in;
    line_eff[TIMER_BIT] = src_in[TIMER_BIT] | (|timer_in);
    rise = line_eff & ~line_q;
    fall = ~line_eff & line_q;
    pend_nxt = ((pend_q | rise) & ~fall) & ~clr_mask & LIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      pend_q <= '0;
    end else begin
      line_q <= line_eff;
      pend_q <= pend_nxt;
    end
  end

  assign pending = pend_q;

  p_level_zero_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~LIVE) == '0);

  p_mask_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0) |=> ((pend_q & $past(clr_mask)) == '0));

  p_fall_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fall != '0) |=> ((pend_q & $past(fall)) == '0));

  p_rise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise & LIVE & ~clr_mask) != '0) |=> ((pend_q & $past(rise & LIVE & ~clr_mask)) == $past(rise & LIVE & ~clr_mask)));

endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 16,
  localparam int TGT_W = $clog2(NUM_CPU)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       reg_idx,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  input  logic [SRC_N-1:0] pending,
  output logic [SRC_N-1:0] dis,
  output logic [TGT_W-1:0] tgt,
  output logic [SRC_N-1:0] clr_mask,
  output logic [31:0]      reg_rdata
);

  logic [SRC_N-1:0] dis_q, dis_nxt;
  logic [TGT_W-1:0] tgt_q, tgt_nxt;
  logic [SRC_N-1:0] sel;
  logic             wr_en, wr_mask, wr_tgt;

  always_comb begin
    sel     = reg_wdata & DIS_VALID;
    wr_en   = reg_wr && (reg_idx == IDX_ENABLE);
    wr_mask = reg_wr && (reg_idx == IDX_MASK);
    wr_tgt  = reg_wr && (reg_idx == IDX_TGT);
    dis_nxt = dis_q;
    if (wr_en)   dis_nxt = dis_q & ~sel;
    if (wr_mask) dis_nxt = dis_q | sel;
    tgt_nxt = wr_tgt ? reg_wdata[TGT_W-1:0] : tgt_q;
    clr_mask = wr_mask ? sel : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= DIS_VALID;
      tgt_q <= '0;
    end else begin
      if (wr_en || wr_mask) dis_q <= dis_nxt;
      if (wr_tgt)           tgt_q <= tgt_nxt;
    end
  end

  always_comb begin
    case (reg_idx)
      IDX_PEND: begin
        reg_rdata = pending;
        reg_rdata[GLOBAL_OFF_BIT] = 1'b0;
      end
      IDX_DIS: reg_rdata = dis_q & DIS_VALID;
      IDX_TGT: reg_rdata = 32'(tgt_q);
      default: reg_rdata = '0;
    endcase
  end

  assign dis = dis_q;
  assign tgt = tgt_q;

  p_dis_in_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q & ~DIS_VALID) == '0);

  p_enable_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == IDX_ENABLE) |=> ((dis_q & $past(reg_wdata & DIS_VALID)) == '0));

  p_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == IDX_MASK) |=> ((dis_q & $past(reg_wdata & DIS_VALID)) == $past(reg_wdata & DIS_VALID)));

  p_tgt_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == IDX_TGT) |=> (tgt_q == $past(reg_wdata[TGT_W-1:0])));

endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 16,
  localparam int TGT_W = $clog2(NUM_CPU)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SRC_N-1:0]         pending,
  input  logic [SRC_N-1:0]         dis,
  input  logic [TGT_W-1:0]         tgt,
  output logic [NUM_CPU*LVL_N-1:0] cpu_lvl
);

  logic [SRC_N-1:0] gated;
  logic [LVL_N-1:0] vec;

  always_comb begin
    gated = dis[GLOBAL_OFF_BIT] ? '0 : (pending & ~dis);
    vec = '0;
    for (int b = 0; b < SRC_N; b++) begin
      if (gated[b]) vec[src_level(b)] = 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign cpu_lvl[c*LVL_N +: LVL_N] = (tgt == TGT_W'(c)) ? vec : '0;

    p_off_target_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt != TGT_W'(c)) |-> (cpu_lvl[c*LVL_N +: LVL_N] == '0));
  end

  p_global_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dis[GLOBAL_OFF_BIT] |-> (cpu_lvl == '0));

  p_single_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_lvl & ~({{(NUM_CPU-1)*LVL_N{1'b0}}, {LVL_N{1'b1}}} << (tgt*LVL_N))) == '0);

endmodule

// File: rtl/irq_level_router_top.sv
module irq_level_router_top
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU   = 16,
  parameter int TIMER_BIT = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [31:0]               src_in,
  input  logic [NUM_CPU-1:0]        timer_in,
  input  logic [2:0]                reg_idx,
  input  logic                      reg_wr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  output logic [NUM_CPU*16-1:0]     cpu_lvl
);

  localparam int TGT_W = $clog2(NUM_CPU);

  logic [1:0]       rst_sync;
  logic             rst_i_n;
  logic [SRC_N-1:0] pending, dis, clr_mask;
  logic [TGT_W-1:0] tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  irq_pending_capture #(.NUM_CPU(NUM_CPU), .TIMER_BIT(TIMER_BIT)) u_pend (
    .clk(clk), .rst_n(rst_i_n), .src_in(src_in), .timer_in(timer_in),
    .clr_mask(clr_mask), .pending(pending)
  );

  irq_ctl_regs #(.NUM_CPU(NUM_CPU)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .reg_idx(reg_idx), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .pending(pending), .dis(dis), .tgt(tgt),
    .clr_mask(clr_mask), .reg_rdata(reg_rdata)
  );

  irq_level_map #(.NUM_CPU(NUM_CPU)) u_map (
    .clk(clk), .rst_n(rst_i_n), .pending(pending), .dis(dis), .tgt(tgt),
    .cpu_lvl(cpu_lvl)
  );

endmodule

// File: tb/tb_irq_level_router_top.sv
module tb_irq_level_router_top;

  localparam int NCPU = 16;
  localparam int TBIT = 19;
  localparam int OW   = NCPU * 16;
  localparam logic [31:0] LIVE = 32'h505DFFBF;

  logic          clk;
  logic          rst_n;
  logic [31:0]   src_in;
  logic [NCPU-1:0] timer_in;
  logic [2:0]    reg_idx;
  logic          reg_wr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [OW-1:0] cpu_lvl;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  irq_level_router_top #(.NUM_CPU(NCPU), .TIMER_BIT(TBIT)) dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .timer_in(timer_in),
    .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_lvl(cpu_lvl)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // stimulus / expected level vector for processor 0
  typedef struct packed { logic [31:0] src; logic [15:0] lvl; } vec_t;
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0001, 16'h0004},   // R1 bit0 -> level 2
    '{32'h0000_0080, 16'h4000},   // R1 bit7 -> level 14
    '{32'h0000_0102, 16'h0008},   // R1 bits 1,8 share level 3
    '{32'h5000_0000, 16'h8000},   // R1 bits 28,30 share level 15
    '{32'h0000_0040, 16'h0000},   // R2 bit6 ignored
    '{32'hAFA2_0040, 16'h0000},   // R2 every level-0 bit ignored
    '{32'h0005_0000, 16'h0050},   // R1 bits 16,18 -> levels 6,4
    '{32'h0058_0000, 16'h0D00},   // R1 bits 19,20,22 -> 10,8,11
    '{32'hFFFF_FFFF, 16'hFFFC},   // R1 all sources
    '{32'h0000_0000, 16'h0000}    // R3 all fall
  };

  task automatic chk(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] v);
    reg_idx = idx;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_idx = idx; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic step_src(input logic [31:0] s);
    @(negedge clk);
    src_in = s;
    @(posedge clk); #1;
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; src_in = '0; timer_in = '0;
    reg_idx = '0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;

    // R10 reset values
    rd(3'd0, v); chk("R10 pending", OW'(v), OW'(0));
    rd(3'd1, v); chk("R10 disable", OW'(v), OW'(32'hF05DFF80));
    rd(3'd4, v); chk("R10 target", OW'(v), OW'(0));
    chk("R10 outputs", cpu_lvl, '0);

    // R5 enable everything
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R5 enable all", OW'(v), OW'(0));

    // table walk, target processor 0
    for (int i = 0; i < NV; i++) begin
      step_src(VECS[i].src);
      chk("R1/R2/R3 vector", cpu_lvl, OW'(VECS[i].lvl));
      rd(3'd0, v); chk("R3/R4 pending read", OW'(v), OW'(VECS[i].src & LIVE & 32'h7FFF_FFFF));
    end

    // R12 latency: nothing before the edge, result right after
    @(negedge clk); src_in = 32'h1; #1;
    chk("R12 before edge", cpu_lvl, '0);
    @(posedge clk); #1;
    chk("R12 after edge", cpu_lvl, OW'(16'h0004));

    // R8 global off
    wr(3'd3, 32'h8000_0000);
    chk("R8 global off", cpu_lvl, '0);
    wr(3'd2, 32'h8000_0000);
    chk("R8 global on", cpu_lvl, OW'(16'h0004));
    step_src(32'h0);

    // R6 mask clears pending, stays clear after re-enable
    step_src(32'h80);
    chk("R6 pre", cpu_lvl, OW'(16'h4000));
    wr(3'd3, 32'h80);
    chk("R6 masked", cpu_lvl, '0);
    rd(3'd0, v); chk("R6 pending cleared", OW'(v), OW'(0));
    wr(3'd2, 32'h80);
    chk("R6 re-enable no pending", cpu_lvl, '0);
    step_src(32'h0);
    step_src(32'h80);
    chk("R6 new edge sets", cpu_lvl, OW'(16'h4000));

    // R6 mask write beats a same-cycle rising edge
    @(negedge clk);
    src_in = 32'h180; reg_idx = 3'd3; reg_wdata = 32'h100; reg_wr = 1'b1;
    @(posedge clk); #1; reg_wr = 1'b0;
    rd(3'd0, v); chk("R6 priority", OW'(v), OW'(32'h80));
    wr(3'd2, 32'h100);
    rd(3'd1, v); chk("R5 re-enabled", OW'(v), OW'(0));

    // R7 / R9 steer to processor 5
    wr(3'd4, 32'h25);
    rd(3'd4, v); chk("R7 target read", OW'(v), OW'(5));
    chk("R9 only target", cpu_lvl, OW'(16'h4000) << (5*16));

    // R11 timer line
    step_src(32'h0);
    @(negedge clk); timer_in[3] = 1'b1;
    @(posedge clk); #1;
    rd(3'd0, v); chk("R11 timer pending", OW'(v), OW'(32'h0008_0000));
    chk("R11 timer level", cpu_lvl, OW'(16'h0400) << (5*16));
    @(negedge clk); timer_in[3] = 1'b0;
    @(posedge clk); #1;
    chk("R11 timer clear", cpu_lvl, '0);

    // R4 unmapped indices
    for (int k = 2; k < 8; k++) begin
      if (k != 4) begin
        rd(3'(k), v); chk("R4 zero index", OW'(v), OW'(0));
      end
    end

    report();
  end

endmodule